// File: doc/BRIEF.md
# Serial Flash Status and Write-Protect Controller

This block is the command front end of a serial flash device that owns the status byte and all write-protection decisions. It samples the SPI pins (mode 0, chip select active low) into the system clock domain. It assembles instruction bytes and keeps the status byte: a busy flag, a write-enable flag, a three-bit protect level and a lock bit. On request it streams that byte back to the host.

When chip select rises, the block judges any write-type instruction. The instruction is rejected if the command framing is wrong, if the write-enable flag is clear, if the device is busy, if the target region is protected, or if the hardware lock is active. An accepted instruction is reported to the array sequencer as a one-cycle strobe with its kind and address. The sequencer later returns a one-cycle done pulse, and that pulse ends the busy period.

Top module: `sfsr_top`

## Requirements
- R1: The status byte reads back as {lock, 0, 0, protect[2:0], writeEnable, busy}, with bit 7 first on the wire. After power-on reset it is 0x00. It is read with opcode 0x05.
- R2: After opcode 0x05, the byte is sent again and again for as long as chip select stays low. Each repeat is sampled fresh when the repeat starts, so a change made during one byte shows in the next one.
- R3: Opcode 0x06 sets writeEnable and opcode 0x04 clears it. Each takes effect only when chip select rises after exactly one byte.
- R4: An instruction does nothing if chip select rises in the middle of a byte or after the wrong number of bytes. The byte counts are: 1 for 0x06, 0x04 and 0xC7; 2 for 0x01; 4 for 0xD8; at least 5 for 0x02.
- R5: When writeEnable is 0, the opcodes 0x01, 0x02, 0xD8 and 0xC7 have no effect and are not reported.
- R6: Opcode 0x01 takes its data byte and loads bit 7 into lock and bits 4:2 into protect. It sets busy and is reported with kind 0.
- R7: When lock is 1 and the write-protect pin is low, opcode 0x01 is ignored. When the pin is high, opcode 0x01 is accepted.
- R8: Page program (0x02, kind 1) and sector erase (0xD8, kind 2) carry a 3-byte address, MSB first. The sector is address bits [20:16]. With protect level p, the number of protected sectors counted down from sector 31 is: 0 when p=0, 32>>(6-p) when p is 1 to 5, and all 32 when p is 6 or 7. A command that targets a protected sector is rejected. An accepted command is reported with its address.
- R9: Bulk erase (0xC7, kind 3) is accepted only when protect is 000.
- R10: Any accepted write-type command sets busy. While busy is 1, every opcode except 0x05 is ignored.
- R11: A done pulse while busy is 1 clears both busy and writeEnable.
- R12: Lock and protect keep their values across any number of chip-select frames and done pulses. Only power-on reset clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Power-on reset, active low |
| spiSck | input | 1 | SPI serial clock (mode 0) |
| spiCsN | input | 1 | SPI chip select, active low |
| spiMosi | input | 1 | Serial data from host |
| spiMiso | output | 1 | Serial data to host, 0 when not reading status |
| wpN | input | 1 | Write-protect pin, active low |
| arrayDone | input | 1 | One-cycle pulse from the sequencer ending a busy period |
| acceptValid | output | 1 | One-cycle strobe: a write-type command was accepted |
| acceptOp | output | 2 | Kind of accepted command: 0 status, 1 program, 2 sector erase, 3 bulk erase |
| acceptAddr | output | 24 | Address captured with the accepted command |

## Verification
A corrupted status flag shows up on the wire at the next status read, and in the very next byte of a read that is already streaming. A wrong gating decision, such as an accept made without writeEnable, while busy, or into a protected sector, puts a strobe on acceptValid one cycle after chip select is seen to rise. The scoreboard reports any strobe it did not expect as soon as it appears. A lost or wrong protect level shows up in the status byte, and also as a later protection decision that goes the wrong way.

// File: rtl/sfsr_pkg.sv
package sfsr_pkg;

  localparam logic [7:0] OPC_WR_ENABLE  = 8'h06;
  localparam logic [7:0] OPC_WR_DISABLE = 8'h04;
  localparam logic [7:0] OPC_RD_STATUS  = 8'h05;
  localparam logic [7:0] OPC_WR_STATUS  = 8'h01;
  localparam logic [7:0] OPC_PAGE_PROG  = 8'h02;
  localparam logic [7:0] OPC_SECT_ERASE = 8'hD8;
  localparam logic [7:0] OPC_BULK_ERASE = 8'hC7;

  typedef enum logic [1:0] {
    ACC_STATUS  = 2'd0,
    ACC_PROGRAM = 2'd1,
    ACC_SECTOR  = 2'd2,
    ACC_BULK    = 2'd3
  } accKind_t;

  // Strobes from control to datapath, valid for one clock
  typedef struct packed {
    logic setWel;
    logic clrWel;
    logic setWip;
    logic finish;
    logic loadSr;
    logic startRead;
  } ctlStrobe_t;

endpackage

// File: rtl/sfsr_datapath.sv
module sfsr_datapath
  import sfsr_pkg::*;
#(
  parameter int ADDR_W      = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spiSck,
  input  logic              spiCsN,
  input  logic              spiMosi,
  input  ctlStrobe_t        strobe,
  output logic              spiMiso,
  output logic              csRise,
  output logic              byteEnd,
  output logic [7:0]        newByte,
  output logic [2:0]        byteCnt,
  output logic              onBoundary,
  output logic [7:0]        opcode,
  output logic [ADDR_W-1:0] addrReg,
  output logic              srwd,
  output logic [2:0]        bp,
  output logic              wel,
  output logic              wip
);

  localparam int PIN_W = 3;
  localparam logic [PIN_W-1:0] PIN_IDLE = 3'b010;  // sck low, cs high, mosi low

  logic [PIN_W-1:0] syncPipe [SYNC_STAGES];
  logic sckS, csS, mosiS, sckQ, csQ;
  logic sckRise, sckFall;
  logic [2:0] bitCnt;
  logic [6:0] shiftIn;
  logic readMode;
  logic [7:0] outShift;
  logic [2:0] outCnt;

  // Pin synchronizer chain
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SYNC_STAGES; i++) syncPipe[i] <= PIN_IDLE;
    end else begin
      syncPipe[0] <= {spiSck, spiCsN, spiMosi};
      for (int i = 1; i < SYNC_STAGES; i++) syncPipe[i] <= syncPipe[i-1];
    end
  end

  assign sckS  = syncPipe[SYNC_STAGES-1][2];
  assign csS   = syncPipe[SYNC_STAGES-1][1];
  assign mosiS = syncPipe[SYNC_STAGES-1][0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sckQ <= 1'b0;
      csQ  <= 1'b1;
    end else begin
      sckQ <= sckS;
      csQ  <= csS;
    end
  end

  assign sckRise = sckS & ~sckQ & ~csS;
  assign sckFall = ~sckS & sckQ & ~csS;
  assign csRise  = csS & ~csQ;

  assign newByte    = {shiftIn, mosiS};
  assign byteEnd    = sckRise && (bitCnt == 3'd7);
  assign onBoundary = (bitCnt == 3'd0);

  // Input shifter, bit and byte counters, opcode and address capture
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bitCnt  <= '0;
      byteCnt <= '0;
      shiftIn <= '0;
      opcode  <= '0;
      addrReg <= '0;
    end else if (csS) begin
      bitCnt  <= '0;
      byteCnt <= '0;
    end else if (sckRise) begin
      shiftIn <= newByte[6:0];
      bitCnt  <= bitCnt + 3'd1;
      if (bitCnt == 3'd7) begin
        if (byteCnt != 3'd7) byteCnt <= byteCnt + 3'd1;
        if (byteCnt == 3'd0) opcode <= newByte;
        else if (byteCnt <= 3'd3) addrReg <= {addrReg[ADDR_W-9:0], newByte};
      end
    end
  end

  // Status output shifter: reloads live status at every byte start
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      readMode <= 1'b0;
      outShift <= '0;
      outCnt   <= '0;
    end else if (csS) begin
      readMode <= 1'b0;
      outCnt   <= '0;
    end else begin
      if (strobe.startRead) readMode <= 1'b1;
      if (sckFall && readMode) begin
        outCnt   <= outCnt + 3'd1;
        outShift <= (outCnt == 3'd0) ? {srwd, 2'b00, bp, wel, wip} : {outShift[6:0], 1'b0};
      end
    end
  end

  assign spiMiso = readMode & outShift[7];

  // Status register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      srwd <= 1'b0;
      bp   <= '0;
      wel  <= 1'b0;
      wip  <= 1'b0;
    end else begin
      if (strobe.loadSr) begin
        srwd <= addrReg[7];
        bp   <= addrReg[4:2];
      end
      if (strobe.setWip)      wip <= 1'b1;
      else if (strobe.finish) wip <= 1'b0;
      if (strobe.setWel)                          wel <= 1'b1;
      else if (strobe.clrWel || strobe.finish)    wel <= 1'b0;
    end
  end

endmodule

// File: rtl/sfsr_control.sv
module sfsr_control
  import sfsr_pkg::*;
#(
  parameter int ADDR_W      = 24,
  parameter int SECTOR_BITS = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csRise,
  input  logic              byteEnd,
  input  logic [7:0]        newByte,
  input  logic [2:0]        byteCnt,
  input  logic              onBoundary,
  input  logic [7:0]        opcode,
  input  logic [ADDR_W-1:0] addrReg,
  input  logic              srwd,
  input  logic [2:0]        bp,
  input  logic              wel,
  input  logic              wip,
  input  logic              wpN,
  input  logic              arrayDone,
  output ctlStrobe_t        strobe,
  output logic              acceptValid,
  output logic [1:0]        acceptOp,
  output logic [ADDR_W-1:0] acceptAddr
);

  localparam int CNT_W = SECTOR_BITS + 1;
  localparam logic [CNT_W-1:0] NUM_SECT = CNT_W'(1) << SECTOR_BITS;

  logic [SECTOR_BITS-1:0] sectorIdx;
  logic [CNT_W-1:0] protSpan;
  logic regionLocked, hwLock, frameEnd;
  logic accept;
  accKind_t acceptKind;

  assign sectorIdx = addrReg[16 +: SECTOR_BITS];
  assign hwLock    = srwd & ~wpN;
  assign frameEnd  = csRise & onBoundary & ~wip;

  always_comb begin
    case (bp)
      3'd0:       protSpan = '0;
      3'd6, 3'd7: protSpan = NUM_SECT;
      default:    protSpan = NUM_SECT >> (3'd6 - bp);
    endcase
  end

  assign regionLocked = ({1'b0, sectorIdx} >= (NUM_SECT - protSpan));

  always_comb begin
    strobe     = '0;
    accept     = 1'b0;
    acceptKind = ACC_STATUS;
    strobe.finish    = arrayDone & wip;
    strobe.startRead = byteEnd && (byteCnt == 3'd0) && (newByte == OPC_RD_STATUS);
    if (frameEnd) begin
      case (opcode)
        OPC_WR_ENABLE:  strobe.setWel = (byteCnt == 3'd1);
        OPC_WR_DISABLE: strobe.clrWel = (byteCnt == 3'd1);
        OPC_WR_STATUS: begin
          accept        = (byteCnt == 3'd2) && wel && !hwLock;
          strobe.loadSr = accept;
          acceptKind    = ACC_STATUS;
        end
        OPC_PAGE_PROG: begin
          accept     = (byteCnt >= 3'd5) && wel && !regionLocked;
          acceptKind = ACC_PROGRAM;
        end
        OPC_SECT_ERASE: begin
          accept     = (byteCnt == 3'd4) && wel && !regionLocked;
          acceptKind = ACC_SECTOR;
        end
        OPC_BULK_ERASE: begin
          accept     = (byteCnt == 3'd1) && wel && (bp == 3'd0);
          acceptKind = ACC_BULK;
        end
        default: ;
      endcase
    end
    strobe.setWip = accept;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acceptValid <= 1'b0;
      acceptOp    <= '0;
      acceptAddr  <= '0;
    end else begin
      acceptValid <= accept;
      if (accept) begin
        acceptOp   <= acceptKind;
        acceptAddr <= addrReg;
      end
    end
  end

endmodule

// File: rtl/sfsr_top.sv
module sfsr_top
  import sfsr_pkg::*;
#(
  parameter int ADDR_W      = 24,
  parameter int SECTOR_BITS = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spiSck,
  input  logic              spiCsN,
  input  logic              spiMosi,
  output logic              spiMiso,
  input  logic              wpN,
  input  logic              arrayDone,
  output logic              acceptValid,
  output logic [1:0]        acceptOp,
  output logic [ADDR_W-1:0] acceptAddr
);

  ctlStrobe_t strobe;
  logic csRise, byteEnd, onBoundary;
  logic [7:0] newByte, opcode;
  logic [2:0] byteCnt;
  logic [ADDR_W-1:0] addrReg;
  logic srwd, wel, wip;
  logic [2:0] bp;
  logic [7:0] statusByte;

  assign statusByte = {srwd, 2'b00, bp, wel, wip};

  sfsr_datapath #(.ADDR_W(ADDR_W), .SYNC_STAGES(SYNC_STAGES)) dp_i (
    .clk(clk), .rst_n(rst_n), .spiSck(spiSck), .spiCsN(spiCsN), .spiMosi(spiMosi),
    .strobe(strobe), .spiMiso(spiMiso), .csRise(csRise), .byteEnd(byteEnd),
    .newByte(newByte), .byteCnt(byteCnt), .onBoundary(onBoundary), .opcode(opcode),
    .addrReg(addrReg), .srwd(srwd), .bp(bp), .wel(wel), .wip(wip)
  );

  sfsr_control #(.ADDR_W(ADDR_W), .SECTOR_BITS(SECTOR_BITS)) ctl_i (
    .clk(clk), .rst_n(rst_n), .csRise(csRise), .byteEnd(byteEnd), .newByte(newByte),
    .byteCnt(byteCnt), .onBoundary(onBoundary), .opcode(opcode), .addrReg(addrReg),
    .srwd(srwd), .bp(bp), .wel(wel), .wip(wip), .wpN(wpN), .arrayDone(arrayDone),
    .strobe(strobe), .acceptValid(acceptValid), .acceptOp(acceptOp), .acceptAddr(acceptAddr)
  );

endmodule

// File: rtl/sfsr_checker.sv
module sfsr_checker (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] statusByte,
  input logic       acceptValid,
  input logic [1:0] acceptOp,
  input logic       arrayDone
);

  AST_ACCEPT_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
    acceptValid |-> $past(statusByte[1])); // R5

  AST_ACCEPT_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    acceptValid |-> !$past(statusByte[0])); // R10

  AST_BUSY_RISE_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(statusByte[0]) |-> acceptValid); // R10

  AST_BULK_UNPROTECTED: assert property (@(posedge clk) disable iff (!rst_n)
    (acceptValid && acceptOp == 2'd3) |-> ($past(statusByte[4:2]) == 3'd0)); // R9

  AST_PROTECT_ONLY_BY_WRSR: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(statusByte[7:2]) |-> (acceptValid && acceptOp == 2'd0)); // R6

  AST_DONE_CLEARS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (arrayDone && statusByte[0]) |=> (statusByte[1:0] == 2'b00)); // R11

endmodule

bind sfsr_top sfsr_checker chk_i (
  .clk(clk), .rst_n(rst_n), .statusByte(statusByte),
  .acceptValid(acceptValid), .acceptOp(acceptOp), .arrayDone(arrayDone)
);

// File: tb/sfsr_top_tb_top.sv
module sfsr_top_tb_top;

  localparam int HALF = 5;  // system clocks per SPI half period

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, spiSck, spiCsN, spiMosi, spiMiso, wpN, arrayDone;
  logic acceptValid;
  logic [1:0] acceptOp;
  logic [23:0] acceptAddr;

  sfsr_top dut_i (
    .clk(clk), .rst_n(rst_n), .spiSck(spiSck), .spiCsN(spiCsN), .spiMosi(spiMosi),
    .spiMiso(spiMiso), .wpN(wpN), .arrayDone(arrayDone), .acceptValid(acceptValid),
    .acceptOp(acceptOp), .acceptAddr(acceptAddr)
  );

  typedef struct {
    logic [1:0]  op;
    logic [23:0] addr;
    bit          useAddr;
  } expItem_t;

  expItem_t expQ[$];
  int checks = 0;
  int fails = 0;
  bit finished = 0;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic shiftBit(input logic b, output logic sampled);
    spiMosi = b;
    waitClk(HALF);
    sampled = spiMiso;
    spiSck = 1'b1;
    waitClk(HALF);
    spiSck = 1'b0;
  endtask

  task automatic pulseDone();
    arrayDone = 1'b1;
    waitClk(1);
    arrayDone = 1'b0;
    waitClk(3);
  endtask

  // frame: first byte in [47:40]; extraBits are trailing partial-byte bits
  task automatic sendFrame(input logic [47:0] frame, input int nBytes, input int extraBits);
    logic s;
    spiCsN = 1'b0;
    waitClk(HALF);
    for (int k = 0; k < nBytes; k++)
      for (int j = 7; j >= 0; j--) shiftBit(frame[47 - 8*k - (7 - j)], s);
    for (int e = 0; e < extraBits; e++) shiftBit(1'b1, s);
    waitClk(HALF);
    spiCsN = 1'b1;
    waitClk(8);
  endtask

  task automatic readStatus(input int nOut, input bit doneMid, output logic [7:0] b0, output logic [7:0] b1);
    logic s;
    logic [7:0] cur;
    b0 = '0;
    b1 = '0;
    spiCsN = 1'b0;
    waitClk(HALF);
    for (int j = 7; j >= 0; j--) shiftBit(sfsr_pkg::OPC_RD_STATUS[j], s);
    for (int k = 0; k < nOut; k++) begin
      for (int j = 7; j >= 0; j--) begin
        shiftBit(1'b0, s);
        cur[j] = s;
        if (doneMid && k == 0 && j == 1) pulseDone();
      end
      if (k == 0) b0 = cur; else b1 = cur;
    end
    waitClk(HALF);
    spiCsN = 1'b1;
    waitClk(8);
  endtask

  task automatic expectStatus(input string req, input logic [7:0] exp);
    logic [7:0] a, b;
    readStatus(1, 1'b0, a, b);
    check(req, a, exp);
  endtask

  task automatic push(input logic [1:0] op, input logic [23:0] addr, input bit useAddr);
    expItem_t it;
    it.op = op;
    it.addr = addr;
    it.useAddr = useAddr;
    expQ.push_back(it);
  endtask

  task automatic wren();  sendFrame({8'h06, 40'h0}, 1, 0); endtask
  task automatic wrdi();  sendFrame({8'h04, 40'h0}, 1, 0); endtask
  task automatic bulk();  sendFrame({8'hC7, 40'h0}, 1, 0); endtask
  task automatic wrsr(input logic [7:0] v); sendFrame({8'h01, v, 32'h0}, 2, 0); endtask
  task automatic serase(input logic [23:0] a); sendFrame({8'hD8, a, 16'h0}, 4, 0); endtask
  task automatic pprog(input logic [23:0] a, input int nData);
    sendFrame({8'h02, a, 8'hA5, 8'h5A}, 4 + nData, 0);
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (rst_n === 1'b1 && acceptValid === 1'b1) begin
      if (expQ.size() == 0) begin
        checks++;
        fails++;
        $display("FAIL R5/R8/R9/R10: unexpected accept actual op %0d addr 0x%0h expected none", acceptOp, acceptAddr);
      end else begin
        expItem_t it;
        it = expQ.pop_front();
        check("R6/R8/R9 accept kind", acceptOp, it.op);
        if (it.useAddr) check("R8 accept address", acceptAddr, it.addr);
      end
    end
  end

  initial begin
    waitClk(150000);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] a, b;
    rst_n = 1'b0; spiSck = 1'b0; spiCsN = 1'b1; spiMosi = 1'b0; wpN = 1'b1; arrayDone = 1'b0;
    waitClk(5);
    rst_n = 1'b1;
    waitClk(5);

    expectStatus("R1 reset value", 8'h00);

    // R4: framing errors
    sendFrame({8'h06, 40'h0}, 1, 3);
    expectStatus("R4 wren off boundary", 8'h00);
    sendFrame({8'h06, 8'h06, 32'h0}, 2, 0);
    expectStatus("R4 wren two bytes", 8'h00);

    // R5: write enable clear
    pprog(24'h000100, 1);
    bulk();
    expectStatus("R5 no enable", 8'h00);

    // R3
    wren();
    expectStatus("R3 set enable", 8'h02);
    wrdi();
    expectStatus("R3 clear enable", 8'h00);

    // R6 / R10 / R11
    wren();
    push(2'd0, 24'h0, 0);
    wrsr(8'h8C);
    expectStatus("R6 R10 status write busy", 8'h8F);
    wren();
    wrdi();
    expectStatus("R10 ignored while busy", 8'h8F);
    pulseDone();
    expectStatus("R11 done clears flags", 8'h8C);
    readStatus(2, 1'b0, a, b);
    check("R2 stream byte 0", a, 8'h8C);
    check("R2 stream byte 1", b, 8'h8C);

    // R7 hardware lock
    wpN = 1'b0;
    wren();
    wrsr(8'h00);
    expectStatus("R7 locked write ignored", 8'h8E);
    wpN = 1'b1;
    push(2'd0, 24'h0, 0);
    wrsr(8'h0C);
    expectStatus("R7 unlocked write accepted", 8'h0F);
    pulseDone();
    expectStatus("R12 protect kept", 8'h0C);

    // R8 with protect 3: sectors 28..31 locked
    wren();
    serase(24'h1C0000);
    expectStatus("R8 protected sector rejected", 8'h0E);
    push(2'd2, 24'h1B0000, 1);
    serase(24'h1B0000);
    readStatus(2, 1'b1, a, b);
    check("R2 live stream busy", a, 8'h0F);
    check("R2 R11 live stream after done", b, 8'h0C);

    // R9 / R4
    wren();
    bulk();
    expectStatus("R9 bulk refused with protect", 8'h0E);
    pprog(24'h000100, 0);
    expectStatus("R4 program without data", 8'h0E);
    push(2'd1, 24'h000100, 1);
    pprog(24'h000100, 1);
    expectStatus("R8 R10 program accepted busy", 8'h0F);
    pulseDone();

    wren();
    push(2'd0, 24'h0, 0);
    wrsr(8'h00);
    pulseDone();
    expectStatus("R6 protect cleared", 8'h00);
    wren();
    push(2'd3, 24'h0, 0);
    bulk();
    expectStatus("R9 bulk accepted busy", 8'h03);
    pulseDone();

    // R8 protect 7 and protect 1
    wren();
    push(2'd0, 24'h0, 0);
    wrsr(8'h1C);
    pulseDone();
    expectStatus("R6 protect 7", 8'h1C);
    wren();
    pprog(24'h000000, 1);
    expectStatus("R8 whole array locked", 8'h1E);
    push(2'd0, 24'h0, 0);
    wrsr(8'h04);
    pulseDone();
    expectStatus("R6 protect 1", 8'h04);
    wren();
    serase(24'h1F0000);
    expectStatus("R8 top sector locked", 8'h06);
    push(2'd2, 24'h1E0000, 1);
    serase(24'h1E0000);
    pulseDone();
    expectStatus("R12 protect across frames", 8'h04);

    // R12 power-on reset clears
    rst_n = 1'b0;
    waitClk(4);
    rst_n = 1'b1;
    waitClk(4);
    expectStatus("R12 reset clears protect", 8'h00);

    check("R10 scoreboard drained", expQ.size(), 0);

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule